// File: doc/BRIEF.md
# Triangle Offset Generator

This block forms the output code of one converter channel. On every accepted conversion trigger it adds a triangle-shaped count to the base value held for the channel. It clamps the sum to the data range and loads it into the channel output register. The count moves one step per accepted trigger. It climbs from zero to a peak chosen by a 4-bit amplitude field, then falls back to zero, and repeats. It never moves between triggers.

Triangle generation is on when bit 1 of the 2-bit wave mode input is set. With that bit clear, the held value passes through unchanged. Two instances can sit side by side with separate amplitudes and separate trigger lines. When trigger mode is off, the output follows the held value one cycle later and triggers are ignored.

Top module: `tri_offset_gen`

## Requirements
- R1: During reset and on the first cycle after it, `out_data` is 0 and `out_load` is 0. The count restarts at 0 and rises.
- R2: A trigger accepted on a clock edge loads `out_data` on the third edge counting that one. `out_load` is high for exactly the one cycle after that load.
- R3: When `wave_mode[1]` is 0 (`wave_mode` 2'b00 or 2'b01), the loaded value equals `hold_data` and the count stays 0.
- R4: When `wave_mode[1]` is 1, the loaded value is `hold_data` plus the count held before that trigger. The count then moves by one toward its current turning point.
- R5: The peak count is 2^(`amp_sel`+1) − 1, capped at 4095 for `amp_sel` ≥ 11. The sequence is 0, 1, …, peak, peak−1, …, 0, 1, …, and each value appears once per slope.
- R6: A sum above 4095 is loaded as 4095 and does not wrap.
- R7: The count does not change on cycles without an accepted trigger. After an idle gap, the next trigger continues the sequence.
- R8: A trigger that arrives while a conversion is still in flight (the two cycles after acceptance) is ignored. It produces no load and does not advance the count.
- R9: A cycle with `wave_mode[1]` at 0 returns the count to 0 and its direction to rising.
- R10: With `trig_en` at 0, `trig` is ignored, `out_load` stays 0, the count holds, and `out_data` takes `hold_data` one edge later.
- R11: With `trig_en` at 1, `out_data` changes only on a cycle where `out_load` is high.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| wave_mode | input | 2 | Wave select; bit 1 set enables triangle offset |
| amp_sel | input | 4 | Amplitude code; peak = 2^(amp_sel+1) − 1 |
| trig_en | input | 1 | 1: conversions start on `trig`; 0: output follows `hold_data` |
| trig | input | 1 | Conversion trigger, sampled each edge |
| hold_data | input | 12 | Base value held for the channel |
| out_data | output | 12 | Channel output register |
| out_load | output | 1 | High for one cycle after a triggered load |

## Verification
On every cycle, the assertions check several properties:
- the three-edge load latency and the single-cycle load pulse;
- that the count only moves together with a load or a wave clear, and then only by one;
- that clearing the wave mode zeroes the count;
- that the output holds between loads in trigger mode.

The exact values need the bench's scenarios:
- the turning points at the peak and at zero for several amplitudes;
- saturation at the top of the range;
- a second trigger inside the in-flight window being dropped;
- the sequence resuming after idle gaps and after trigger mode was switched off.

// File: rtl/tri_offset_pkg.sv
// Package: shared types and fixed timing constants for the triangle offset generator.
// Assumes: the conversion latency is a fixed small number of edges.
package tri_offset_pkg;
    // Edges from trigger acceptance to the output load, counting the accepting edge.
    localparam int CONV_LAT = 3;

    // Slope direction of the triangle count.
    typedef enum logic {
        DIR_UP   = 1'b0,
        DIR_DOWN = 1'b1
    } tri_dir_e;
endpackage

// File: rtl/tri_wave_counter.sv
// Module: triangle step counter.
// Moves one step per `step` pulse, between 0 and a peak derived from the amplitude code.
// Assumes: `enable` low clears the state; `step` is a single-cycle pulse.
module tri_wave_counter #(
    parameter int DATA_W = 12,
    parameter int AMP_W  = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              enable,
    input  logic              step,
    input  logic [AMP_W-1:0]  amp,
    output logic [DATA_W-1:0] count
);
    import tri_offset_pkg::*;

    localparam int               TOP_AMP = DATA_W - 1;
    localparam logic [DATA_W-1:0] ONE    = DATA_W'(1);
    localparam logic [DATA_W:0]   WONE   = (DATA_W+1)'(1);

    tri_dir_e          dir_q;
    logic [DATA_W-1:0] peak;
    logic [DATA_W:0]   peak_wide;

    // Peak = 2^(amp+1)-1, capped at all ones once the shift would leave the data width.
    always_comb begin
        peak_wide = (WONE << (int'(amp) + 1)) - WONE;
        if (int'(amp) >= TOP_AMP) begin
            peak = '1;
        end else begin
            peak = peak_wide[DATA_W-1:0];
        end
    end

    // Count and direction update: reset or disable clears, each step moves one toward the turning point.
    always_ff @(posedge clk) begin
        if (!rst_n || !enable) begin
            count <= '0;
            dir_q <= DIR_UP;
        end else if (step) begin
            case (dir_q)
                DIR_UP: begin
                    if (count >= peak) begin
                        dir_q <= DIR_DOWN;
                        count <= count - ONE;
                    end else begin
                        count <= count + ONE;
                    end
                end
                default: begin
                    if (count == '0) begin
                        dir_q <= DIR_UP;
                        count <= ONE;
                    end else begin
                        count <= count - ONE;
                    end
                end
            endcase
        end
    end
endmodule

// File: rtl/tri_sum_sat.sv
// Module: saturating adder.
// Adds two unsigned values and clamps the result to all ones on overflow.
// Assumes: unsigned operands of equal width; purely combinational.
module tri_sum_sat #(
    parameter int DATA_W = 12
) (
    input  logic [DATA_W-1:0] base,
    input  logic [DATA_W-1:0] offset,
    output logic [DATA_W-1:0] sum
);
    logic [DATA_W:0] wide;

    // Add with one guard bit, then clamp when the guard bit is set.
    always_comb begin
        wide = {1'b0, base} + {1'b0, offset};
        sum  = wide[DATA_W] ? {DATA_W{1'b1}} : wide[DATA_W-1:0];
    end
endmodule

// File: rtl/tri_conv_pipe.sv
// Module: conversion delay line plus output register.
// Carries an accepted sum through DEPTH-1 stages, then loads the output register.
// A direct load path serves the untriggered mode when no conversion is retiring.
// Assumes: DEPTH >= 2; the caller prevents new entries while `busy`.
module tri_conv_pipe #(
    parameter int DATA_W = 12,
    parameter int DEPTH  = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_valid,
    input  logic [DATA_W-1:0] in_data,
    input  logic              sw_load,
    input  logic [DATA_W-1:0] sw_data,
    output logic              busy,
    output logic              retire,
    output logic [DATA_W-1:0] out_data,
    output logic              out_load
);
    localparam int NSTG = DEPTH - 1;

    logic [NSTG-1:0]   vld;
    logic [DATA_W-1:0] dat [NSTG];

    // Stage shift: stage 0 takes the new sum, later stages take their predecessor.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            vld <= '0;
            for (int i = 0; i < NSTG; i++) begin
                dat[i] <= '0;
            end
        end else begin
            for (int i = 0; i < NSTG; i++) begin
                if (i == 0) begin
                    vld[i] <= in_valid;
                    dat[i] <= in_data;
                end else begin
                    vld[i] <= vld[i-1];
                    dat[i] <= dat[i-1];
                end
            end
        end
    end

    assign retire = vld[NSTG-1];
    assign busy   = |vld;

    // Output register: a retiring conversion takes priority over the direct load.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_data <= '0;
            out_load <= 1'b0;
        end else begin
            out_load <= retire;
            if (retire) begin
                out_data <= dat[NSTG-1];
            end else if (sw_load) begin
                out_data <= sw_data;
            end
        end
    end
endmodule

// File: rtl/tri_offset_gen.sv
// Module: triangle offset generator for one converter channel (top).
// Accepts a trigger when idle and adds the triangle count to the held value.
// Loads the clamped sum after the fixed conversion latency, and steps the count at that load.
// Assumes: synchronous active-low reset; trig sampled every edge.
module tri_offset_gen #(
    parameter int DATA_W = 12,
    parameter int AMP_W  = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [1:0]        wave_mode,
    input  logic [AMP_W-1:0]  amp_sel,
    input  logic              trig_en,
    input  logic              trig,
    input  logic [DATA_W-1:0] hold_data,
    output logic [DATA_W-1:0] out_data,
    output logic              out_load
);
    import tri_offset_pkg::*;

    logic              tri_on;
    logic              busy;
    logic              retire;
    logic              accept;
    logic [DATA_W-1:0] wave_cnt;
    logic [DATA_W-1:0] offset;
    logic [DATA_W-1:0] sum;

    // Triangle mode is bit 1 of the wave select; a trigger is taken only in trigger mode and when idle.
    assign tri_on = wave_mode[1];
    assign accept = trig_en && trig && !busy;
    assign offset = tri_on ? wave_cnt : '0;

    tri_wave_counter #(
        .DATA_W (DATA_W),
        .AMP_W  (AMP_W)
    ) u_cnt (
        .clk    (clk),
        .rst_n  (rst_n),
        .enable (tri_on),
        .step   (retire),
        .amp    (amp_sel),
        .count  (wave_cnt)
    );

    tri_sum_sat #(
        .DATA_W (DATA_W)
    ) u_sum (
        .base   (hold_data),
        .offset (offset),
        .sum    (sum)
    );

    tri_conv_pipe #(
        .DATA_W (DATA_W),
        .DEPTH  (CONV_LAT)
    ) u_pipe (
        .clk      (clk),
        .rst_n    (rst_n),
        .in_valid (accept),
        .in_data  (sum),
        .sw_load  (!trig_en),
        .sw_data  (hold_data),
        .busy     (busy),
        .retire   (retire),
        .out_data (out_data),
        .out_load (out_load)
    );
endmodule

// File: rtl/tri_offset_gen_chk.sv
// Module: assertion checker for tri_offset_gen, attached by bind.
// Assumes: conversion latency of three edges, as fixed in the package.
module tri_offset_gen_chk #(
    parameter int DATA_W = 12
) (
    input logic              clk,
    input logic              rst_n,
    input logic [1:0]        wave_mode,
    input logic              trig_en,
    input logic              accept,
    input logic [DATA_W-1:0] count,
    input logic [DATA_W-1:0] out_data,
    input logic              out_load
);
    AST_RESET_STATE: assert property (@(posedge clk)
        !rst_n |=> (out_data == '0 && !out_load)); // R1

    AST_LOAD_LATENCY: assert property (@(posedge clk) disable iff (!rst_n)
        out_load |-> $past(accept, 3)); // R2

    AST_LOAD_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        out_load |=> !out_load); // R2

    AST_COUNT_ON_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(count) |-> (out_load || !$past(wave_mode[1]))); // R7

    AST_COUNT_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        (!$stable(count) && $past(wave_mode[1])) |->
        (count == $past(count) + DATA_W'(1) || count == $past(count) - DATA_W'(1))); // R4

    AST_CLEAR_COUNT: assert property (@(posedge clk) disable iff (!rst_n)
        !wave_mode[1] |=> (count == '0)); // R9

    AST_HOLD_OUT: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(trig_en) && !out_load) |-> $stable(out_data)); // R11
endmodule

bind tri_offset_gen tri_offset_gen_chk #(.DATA_W(DATA_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .wave_mode (wave_mode),
    .trig_en   (trig_en),
    .accept    (accept),
    .count     (wave_cnt),
    .out_data  (out_data),
    .out_load  (out_load)
);

// File: tb/tri_offset_gen_bench.sv
// Scoreboard bench: the driver pushes expected loads, the monitor pops them as out_load fires.
module tri_offset_gen_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [1:0]  wave_mode = 2'b00;
    logic [3:0]  amp_sel = 4'd0;
    logic        trig_en = 1'b1;
    logic        trig = 1'b0;
    logic [11:0] hold_data = '0;
    logic [11:0] out_data;
    logic        out_load;

    int nchk = 0;
    int nerr = 0;
    logic [11:0] exp_q [$];
    string       tag_q [$];

    int  m_cnt = 0;
    bit  m_down = 1'b0;

    always #10 clk = ~clk;

    tri_offset_gen u_tri_offset_gen (
        .clk       (clk),
        .rst_n     (rst_n),
        .wave_mode (wave_mode),
        .amp_sel   (amp_sel),
        .trig_en   (trig_en),
        .trig      (trig),
        .hold_data (hold_data),
        .out_data  (out_data),
        .out_load  (out_load)
    );

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        nchk++;
        if (!ok) begin
            nerr++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    function automatic int peak_of(input int a);
        if (a >= 11) return 4095;
        return (1 << (a + 1)) - 1;
    endfunction

    // Model step per accepted trigger, from R4/R5.
    task automatic model_step();
        if (!m_down) begin
            if (m_cnt >= peak_of(amp_sel)) begin m_down = 1'b1; m_cnt--; end
            else m_cnt++;
        end else begin
            if (m_cnt == 0) begin m_down = 1'b0; m_cnt = 1; end
            else m_cnt--;
        end
    endtask

    // Driver: one trigger, expected value pushed, latency checked per R2.
    task automatic convert(input logic [11:0] h, input string tag);
        int s;
        @(negedge clk);
        hold_data = h;
        trig = 1'b1;
        s = int'(h) + (wave_mode[1] ? m_cnt : 0);
        exp_q.push_back(s > 4095 ? 12'hFFF : 12'(s));
        tag_q.push_back(tag);
        if (wave_mode[1]) model_step();
        @(negedge clk);
        trig = 1'b0;
        chk(!out_load, "R2 early load 1", int'(out_load), 0);
        @(negedge clk);
        chk(!out_load, "R2 early load 2", int'(out_load), 0);
        @(negedge clk);
        chk(out_load, "R2 load on third edge", int'(out_load), 1);
    endtask

    task automatic clear_wave();
        @(negedge clk);
        wave_mode = 2'b00;
        @(negedge clk);
        wave_mode = 2'b10;
        m_cnt = 0;
        m_down = 1'b0;
    endtask

    // Monitor: pop and compare on each load.
    always @(negedge clk) begin
        if (rst_n && out_load) begin
            if (exp_q.size() == 0) begin
                chk(1'b0, "R8/R10 unexpected load", int'(out_data), -1);
            end else begin
                logic [11:0] e;
                string t;
                e = exp_q.pop_front();
                t = tag_q.pop_front();
                chk(out_data == e, t, int'(out_data), int'(e));
            end
        end
    end

    initial begin
        #(20 * 20000);
        chk(1'b0, "watchdog", 0, 1);
        $display("Result: errors=%0d of %0d checks", nerr, nchk);
        $finish;
    end

    initial begin
        logic [11:0] held;
        repeat (4) @(negedge clk);
        chk(out_data == 12'h000, "R1 reset out_data", int'(out_data), 0);
        chk(!out_load, "R1 reset out_load", int'(out_load), 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk(out_data == 12'h000 && !out_load, "R1 after release", int'(out_data), 0);

        // R3: wave off, both codes
        wave_mode = 2'b00;
        convert(12'h100, "R3 wave 00 passthrough");
        wave_mode = 2'b01;
        convert(12'h200, "R3 wave 01 passthrough");

        // R4/R5: amplitude 1, peak 3
        wave_mode = 2'b10;
        amp_sel = 4'd1;
        for (int i = 0; i < 8; i++) convert(12'h010, "R4 R5 triangle amp1");

        // R7/R11: idle gap, output held, sequence continues
        held = out_data;
        repeat (20) @(negedge clk);
        chk(out_data == held, "R11 output held while idle", int'(out_data), int'(held));
        convert(12'h010, "R7 continue after gap");

        // R8: back-to-back trigger, second dropped
        @(negedge clk);
        hold_data = 12'h040;
        trig = 1'b1;
        exp_q.push_back(12'(12'h040 + m_cnt));
        tag_q.push_back("R8 first of pair");
        model_step();
        @(negedge clk);
        @(negedge clk);
        trig = 1'b0;
        repeat (3) @(negedge clk);
        convert(12'h040, "R8 count advanced once");

        // R9: clear resets to 0 rising
        clear_wave();
        convert(12'h300, "R9 restart at zero");
        convert(12'h300, "R9 rising after clear");

        // R5: amplitude 0, peak 1
        clear_wave();
        amp_sel = 4'd0;
        for (int i = 0; i < 4; i++) convert(12'h020, "R5 amp0 peak 1");

        // R6: saturation near the top
        clear_wave();
        amp_sel = 4'd2;
        for (int i = 0; i < 5; i++) convert(12'hFFE, "R6 saturate");

        // R10: untriggered mode
        @(negedge clk);
        trig_en = 1'b0;
        hold_data = 12'h055;
        @(negedge clk);
        chk(out_data == 12'h055, "R10 follows hold", int'(out_data), 12'h055);
        trig = 1'b1;
        @(negedge clk);
        trig = 1'b0;
        repeat (4) @(negedge clk);
        chk(!out_load, "R10 no load pulse", int'(out_load), 0);
        chk(out_data == 12'h055, "R10 still hold", int'(out_data), 12'h055);
        trig_en = 1'b1;
        convert(12'h000, "R10 count unchanged");

        repeat (3) @(negedge clk);
        chk(exp_q.size() == 0, "R2 all expected loads seen", exp_q.size(), 0);
        $display("Result: errors=%0d of %0d checks", nerr, nchk);
        $finish;
    end
endmodule